// File: doc/BRIEF.md
# Status Event Register Group

This block turns a vector of live status lines into a latched, maskable status report with a single summary output. A previous-value register watches the status vector and finds its rising and falling edges. Two programmable transition masks choose which edges count. A counted edge sets a sticky event bit. An enable mask selects which event bits may raise the summary. The summary is the registered OR of the enabled event bits, and it is meant to drive one bit of a parent condition register one level up.

Software reaches the group through a small register port. It has an address, a read strobe, a write strobe, write data and combinational read data. The live condition can be queried. Reading the event register clears it, while reading the enable register leaves it intact. A clear-status strobe empties the event register without touching any mask. Address map: 0 condition, 1 event, 2 enable, 3 rising-edge mask, 4 falling-edge mask; any other address reads as zero.

Top module: `sevt_group`

## Requirements
- R1: A read at address 0 returns the live `cond_in` value in the same cycle, with no latching.
- R2: When a `cond_in` bit goes from 0 to 1 and its rising-edge mask bit (address 3) is 1, the matching event bit is set at that clock edge.
- R3: When a `cond_in` bit goes from 1 to 0 and its falling-edge mask bit (address 4) is 1, the event bit is set. An edge whose mask bit is 0 sets nothing.
- R4: Event bits are sticky and stay set after the condition returns to its earlier value, until they are cleared.
- R5: A read at address 1 with `acc_rd` high returns the event contents, and the register is zero from the next cycle.
- R6: A high `clr_stb` clears the event register at the clock edge and leaves the enable and edge masks unchanged.
- R7: A counted edge arriving in the same cycle as a clear-on-read or a `clr_stb` wins, so its event bit reads as set afterwards.
- R8: Reading the enable register (address 2) does not change it. Writing 0 to it clears it.
- R9: `summary` equals the OR over all bits of (event AND enable), registered, so it follows a change of either register by one clock.
- R10: Writes to address 0 and address 1 have no effect on any register.
- R11: After reset, the event and enable registers are 0, the rising-edge mask is all ones, the falling-edge mask is 0, and `summary` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cond_in | input | WIDTH | Live status condition vector |
| acc_addr | input | 3 | Register address |
| acc_wr | input | 1 | Write strobe |
| acc_rd | input | 1 | Read strobe; clears the event register when address is 1 |
| acc_wdata | input | WIDTH | Write data |
| acc_rdata | output | WIDTH | Combinational read data for `acc_addr` |
| clr_stb | input | 1 | Clear-status strobe, clears events only |
| summary | output | 1 | Registered OR of the enabled event bits |

## Verification
A wrong edge-detector state shows up as an event bit that appears or goes missing at the edge after a condition change, and the next event read exposes it. A wrong enable or event state shows up on `summary` exactly one clock later. Any mask corruption is visible on its read address in the same cycle. The bench runs a behavioural model alongside the design, so a divergence is reported in the cycle where it first becomes visible.

// File: rtl/sevt_pkg.sv
package sevt_pkg;
   localparam int ADDR_W = 3;
   typedef enum logic [ADDR_W-1:0] {
      ADR_COND = 3'd0,
      ADR_EVT  = 3'd1,
      ADR_EN   = 3'd2,
      ADR_RISE = 3'd3,
      ADR_FALL = 3'd4
   } sevt_addr_e;
endpackage

// File: rtl/sevt_edge.sv
module sevt_edge #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] cond_in,
   input  logic [WIDTH-1:0] rise_mask,
   input  logic [WIDTH-1:0] fall_mask,
   output logic [WIDTH-1:0] prev_cond,
   output logic [WIDTH-1:0] set_vec
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_cond <= '0;
      else        prev_cond <= cond_in;
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic up_e, dn_e;
      always_comb begin
         up_e       = cond_in[i] & ~prev_cond[i];
         dn_e       = ~cond_in[i] & prev_cond[i];
         set_vec[i] = (up_e & rise_mask[i]) | (dn_e & fall_mask[i]);
      end
   end
endmodule

// File: rtl/sevt_latch.sv
module sevt_latch #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_vec,
   input  logic             clr_all,
   output logic [WIDTH-1:0] evt_q
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          evt_q[i] <= 1'b0;
         else if (set_vec[i]) evt_q[i] <= 1'b1;
         else if (clr_all)    evt_q[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/sevt_summary.sv
module sevt_summary #(
   parameter int WIDTH      = 16,
   parameter bit REGISTERED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] evt_q,
   input  logic [WIDTH-1:0] en_q,
   output logic             summary
);
   logic any_hit;
   assign any_hit = |(evt_q & en_q);

   if (REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) summary <= 1'b0;
         else        summary <= any_hit;
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign summary = any_hit;
   end
endmodule

// File: rtl/sevt_group.sv
module sevt_group
   import sevt_pkg::*;
#(
   parameter int               WIDTH    = 16,
   parameter logic [WIDTH-1:0] RISE_RST = '1,
   parameter logic [WIDTH-1:0] FALL_RST = '0,
   parameter bit               SUM_REG  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WIDTH-1:0]  cond_in,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_wr,
   input  logic              acc_rd,
   input  logic [WIDTH-1:0]  acc_wdata,
   output logic [WIDTH-1:0]  acc_rdata,
   input  logic              clr_stb,
   output logic              summary
);
   if (WIDTH < 1 || WIDTH > 32) begin : g_bad_width
      $error("sevt_group: WIDTH must be 1..32");
   end

   logic [WIDTH-1:0] en_q, rise_q, fall_q;
   logic [WIDTH-1:0] prev_cond, set_vec, evt_q;
   logic             rd_evt, clr_all;
   sevt_addr_e       adr;

   assign adr     = sevt_addr_e'(acc_addr);
   assign rd_evt  = acc_rd && (adr == ADR_EVT);
   assign clr_all = rd_evt || clr_stb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         rise_q <= RISE_RST;
         fall_q <= FALL_RST;
      end else if (acc_wr) begin
         case (adr)
            ADR_EN:   en_q   <= acc_wdata;
            ADR_RISE: rise_q <= acc_wdata;
            ADR_FALL: fall_q <= acc_wdata;
            default:  ;
         endcase
      end
   end

   always_comb begin
      case (adr)
         ADR_COND: acc_rdata = cond_in;
         ADR_EVT:  acc_rdata = evt_q;
         ADR_EN:   acc_rdata = en_q;
         ADR_RISE: acc_rdata = rise_q;
         ADR_FALL: acc_rdata = fall_q;
         default:  acc_rdata = '0;
      endcase
   end

   sevt_edge #(.WIDTH(WIDTH)) u_edge (
      .clk(clk), .rst_n(rst_n), .cond_in(cond_in),
      .rise_mask(rise_q), .fall_mask(fall_q),
      .prev_cond(prev_cond), .set_vec(set_vec)
   );

   sevt_latch #(.WIDTH(WIDTH)) u_latch (
      .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
      .clr_all(clr_all), .evt_q(evt_q)
   );

   sevt_summary #(.WIDTH(WIDTH), .REGISTERED(SUM_REG)) u_sum (
      .clk(clk), .rst_n(rst_n), .evt_q(evt_q), .en_q(en_q),
      .summary(summary)
   );
endmodule

// File: rtl/sevt_group_chk.sv
module sevt_group_chk #(
   parameter int WIDTH = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [WIDTH-1:0] cond_in,
   input logic [2:0]       acc_addr,
   input logic             acc_wr,
   input logic             acc_rd,
   input logic             clr_stb,
   input logic             summary,
   input logic [WIDTH-1:0] prev_cond,
   input logic [WIDTH-1:0] set_vec,
   input logic [WIDTH-1:0] evt_q,
   input logic [WIDTH-1:0] en_q,
   input logic [WIDTH-1:0] rise_q,
   input logic [WIDTH-1:0] fall_q
);
   logic [WIDTH-1:0] up_hit, dn_hit;
   assign up_hit = cond_in & ~prev_cond & rise_q;
   assign dn_hit = ~cond_in & prev_cond & fall_q;

   a_r2_rise_latches: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((evt_q & $past(up_hit)) == $past(up_hit)));

   a_r3_fall_latches: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((evt_q & $past(dn_hit)) == $past(dn_hit)));

   a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_stb && !(acc_rd && acc_addr == 3'd1))
      |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

   a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      clr_stb |=> ((evt_q & ~$past(set_vec)) == '0));

   a_r8_enable_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_wr && acc_addr == 3'd2) |=> $stable(en_q));

   a_r9_summary_follows: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (summary == (|$past(evt_q & en_q))));

   a_r10_masks_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_wr |=> ($stable(rise_q) && $stable(fall_q)));
endmodule

bind sevt_group sevt_group_chk #(.WIDTH(WIDTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .cond_in(cond_in), .acc_addr(acc_addr),
   .acc_wr(acc_wr), .acc_rd(acc_rd), .clr_stb(clr_stb), .summary(summary),
   .prev_cond(prev_cond), .set_vec(set_vec), .evt_q(evt_q), .en_q(en_q),
   .rise_q(rise_q), .fall_q(fall_q)
);

// File: tb/sevt_group_test.sv
`timescale 1ns/1ps
module sevt_group_test;
   localparam int W = 16;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] cond_in = '0;
   logic [2:0]   acc_addr = 3'd0;
   logic         acc_wr = 1'b0;
   logic         acc_rd = 1'b0;
   logic [W-1:0] acc_wdata = '0;
   logic [W-1:0] acc_rdata;
   logic         clr_stb = 1'b0;
   logic         summary;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // behavioural reference state
   logic [W-1:0] m_evt, m_en, m_rise, m_fall, m_prev;
   logic         m_sum;

   always #2.5 clk = ~clk;

   sevt_group #(.WIDTH(W)) uut (
      .clk(clk), .rst_n(rst_n), .cond_in(cond_in), .acc_addr(acc_addr),
      .acc_wr(acc_wr), .acc_rd(acc_rd), .acc_wdata(acc_wdata),
      .acc_rdata(acc_rdata), .clr_stb(clr_stb), .summary(summary)
   );

   task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] model_read();
      case (acc_addr)
         3'd0: return cond_in;
         3'd1: return m_evt;
         3'd2: return m_en;
         3'd3: return m_rise;
         3'd4: return m_fall;
         default: return '0;
      endcase
   endfunction

   function automatic string read_tag();
      case (acc_addr)
         3'd0: return "R1";
         3'd1: return "R5";
         3'd2: return "R8";
         default: return "R3";
      endcase
   endfunction

   // one clock: compare, compute next model state, advance to next negedge
   task automatic cyc();
      logic [W-1:0] n_evt, n_en, n_rise, n_fall;
      logic         n_sum, wipe;
      #0.6;
      chk(read_tag(), acc_rdata, model_read());
      chk("R9", {{(W-1){1'b0}}, summary}, {{(W-1){1'b0}}, m_sum});
      wipe  = clr_stb || (acc_rd && acc_addr == 3'd1);
      n_sum = 1'b0;
      for (int i = 0; i < W; i++) begin
         bit rose, fell;
         rose = cond_in[i] && !m_prev[i];
         fell = !cond_in[i] && m_prev[i];
         if ((rose && m_rise[i]) || (fell && m_fall[i])) n_evt[i] = 1'b1;
         else if (wipe)                                  n_evt[i] = 1'b0;
         else                                            n_evt[i] = m_evt[i];
         if (m_evt[i] && m_en[i]) n_sum = 1'b1;
      end
      n_en = m_en; n_rise = m_rise; n_fall = m_fall;
      if (acc_wr) begin
         if (acc_addr == 3'd2) n_en   = acc_wdata;
         if (acc_addr == 3'd3) n_rise = acc_wdata;
         if (acc_addr == 3'd4) n_fall = acc_wdata;
      end
      @(posedge clk);
      m_evt = n_evt; m_en = n_en; m_rise = n_rise; m_fall = n_fall;
      m_prev = cond_in; m_sum = n_sum;
      @(negedge clk);
   endtask

   task automatic peek(string req, logic [2:0] a, logic [W-1:0] exp);
      acc_addr = a;
      #0.2;
      chk(req, acc_rdata, exp);
   endtask

   task automatic wr(logic [2:0] a, logic [W-1:0] d);
      acc_addr = a; acc_wdata = d; acc_wr = 1'b1;
      cyc();
      acc_wr = 1'b0;
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      m_evt = '0; m_en = '0; m_rise = '1; m_fall = '0; m_prev = '0; m_sum = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset state
      peek("R11", 3'd1, 16'h0000);
      peek("R11", 3'd2, 16'h0000);
      peek("R11", 3'd3, 16'hFFFF);
      peek("R11", 3'd4, 16'h0000);
      chk("R11", {{(W-1){1'b0}}, summary}, '0);

      // R1 live condition, R2 rising edges latch
      cond_in = 16'hA5A5;
      peek("R1", 3'd0, 16'hA5A5);
      cyc();
      peek("R2", 3'd1, 16'hA5A5);
      cyc();
      // falling edges with fall mask 0 set nothing; R4 sticky
      cond_in = 16'h0000;
      cyc();
      peek("R4", 3'd1, 16'hA5A5);
      cyc();
      // R5 clear on read
      acc_rd = 1'b1;
      peek("R5", 3'd1, 16'hA5A5);
      cyc();
      acc_rd = 1'b0;
      peek("R5", 3'd1, 16'h0000);
      cyc();

      // R3 falling mask
      wr(3'd4, 16'h00F0);
      wr(3'd3, 16'h0000);
      cond_in = 16'h00FF;
      cyc();
      peek("R3", 3'd1, 16'h0000);
      cond_in = 16'h0000;
      cyc();
      peek("R3", 3'd1, 16'h00F0);
      cyc();

      // R9 summary latency
      wr(3'd2, 16'h0010);
      chk("R9", {{(W-1){1'b0}}, summary}, '0);
      cyc();
      chk("R9", {{(W-1){1'b0}}, summary}, 16'h0001);

      // R6 clear strobe keeps enable
      clr_stb = 1'b1;
      cyc();
      clr_stb = 1'b0;
      peek("R6", 3'd1, 16'h0000);
      peek("R6", 3'd2, 16'h0010);
      peek("R6", 3'd4, 16'h00F0);
      cyc();

      // R7 edge during clear-on-read wins
      wr(3'd3, 16'hFFFF);
      cond_in = 16'h0001;
      acc_rd = 1'b1;
      acc_addr = 3'd1;
      cyc();
      acc_rd = 1'b0;
      peek("R7", 3'd1, 16'h0001);
      // R7 edge during clear strobe wins
      cond_in = 16'h0003;
      clr_stb = 1'b1;
      cyc();
      clr_stb = 1'b0;
      peek("R7", 3'd1, 16'h0002);

      // R10 writes to condition and event addresses are ignored
      wr(3'd1, 16'hFFFF);
      wr(3'd0, 16'h5555);
      peek("R10", 3'd1, 16'h0002);
      peek("R10", 3'd3, 16'hFFFF);
      peek("R10", 3'd2, 16'h0010);

      // R8 enable read keeps it, write 0 clears
      acc_rd = 1'b1;
      peek("R8", 3'd2, 16'h0010);
      cyc();
      acc_rd = 1'b0;
      peek("R8", 3'd2, 16'h0010);
      wr(3'd2, 16'h0000);
      peek("R8", 3'd2, 16'h0000);
      cyc();

      // mixed stimulus against the model
      for (int k = 0; k < 400; k++) begin
         cond_in   = W'($urandom);
         acc_addr  = 3'($urandom_range(0, 5));
         acc_wr    = ($urandom_range(0, 3) == 0);
         acc_rd    = ($urandom_range(0, 2) == 0);
         acc_wdata = W'($urandom);
         clr_stb   = ($urandom_range(0, 9) == 0);
         cyc();
      end
      acc_wr = 1'b0; acc_rd = 1'b0; clr_stb = 1'b0;
      cyc();

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule